// File: doc/BRIEF.md
# Redundant Dual-Branch CAN Receive/Transmit Combiner

This block sits between one CAN link-layer controller and two parallel physical-layer branches, each with its own transceiver and bus segment. The controller's transmit line is fanned out unchanged to both branches. The two branch receive lines are merged by a wired-AND, so a dominant (low) level seen on either branch reaches the controller at once. Bitwise arbitration is therefore unaffected by the redundancy. If one branch sticks dominant, that branch's transceiver times out its own receive line to recessive, and traffic continues over the other branch.

Each transceiver reports a fault line (high means faulty). The combiner synchronises both fault lines, records each one in a sticky per-branch status bit, and raises a system warning while any sticky bit is set. While a branch's fault line is high, it is dropped from the merge. When the fault line clears, the branch rejoins on its own. Software can mask either branch from the merge.

A diagnostic mode drives the transceivers' silent-mode inputs so that only one chosen branch can transmit. This exposes faults that only show as a missing dominant on a single branch. An explicit transmit-off bit silences both branches. A small register port gives access to all of this state.

Top module: `can_dual_branch_combiner`

## Requirements
- R1: `ctl_rxd` is low exactly when at least one included branch has its `br_rxd` low. A branch that is not included counts as recessive (high). The path has no register.
- R2: Register address 0 holds a two-bit branch-enable mask in bits [1:0], where bit b enables branch b. A branch whose bit is 0 is never included. Reads return the mask in bits [1:0] and zeros above.
- R3: A branch is excluded while its synchronised fault level is high. The synchronised level follows `br_fault` after SYNC_STAGES (default 2) rising clock edges. The branch rejoins the same number of edges after its fault line falls.
- R4: Both bits of `br_txd` always equal `ctl_txd`.
- R5: While diagnostic mode and transmit-off are both 0, `br_silent` is 2'b00.
- R6: Register address 1 holds the mode: bit0 enables diagnostic mode, bit1 selects the transmitting branch, and bit2 is transmit-off. In diagnostic mode with transmit-off at 0, the selected branch has its silent bit at 0 and the other branch has its silent bit at 1.
- R7: While transmit-off is 1, `br_silent` is 2'b11 in any mode.
- R8: Register address 2 holds the sticky fault bits in [1:0]. A bit is set on the edge after its synchronised fault level is high. A written 1 clears the bit, unless the synchronised fault is still high, in which case the set wins.
- R9: Register address 3 reads the synchronised live fault levels in bits [1:0]. Writes to this address have no effect.
- R10: `sys_warn` is high exactly when any sticky fault bit is set.
- R11: After reset, the enable mask is 2'b11, the mode is 0, and the sticky and live fault bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_txd | input | 1 | Transmit data from the controller |
| ctl_rxd | output | 1 | Merged receive data to the controller |
| br_rxd | input | 2 | Receive data from each branch |
| br_fault | input | 2 | Fault line from each branch, high means faulty |
| br_txd | output | 2 | Transmit data to each branch |
| br_silent | output | 2 | Silent-mode input of each branch, high means silent |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 4 | Register write data |
| cfg_rdata | output | 4 | Register read data, combinational from the address |
| sys_warn | output | 1 | Any sticky branch fault is present |

## Verification
A wrong enable or live-fault bit shows up on `ctl_rxd` on the first cycle in which the affected branch carries a dominant level that the other branch does not. A bench that drives the two receive lines independently therefore exposes such an error within a few cycles. A corrupted mode register shows on `br_silent` in the same cycle. A sticky bit that fails to set, or that clears while its fault is live, shows on `sys_warn` and at address 2 one edge after the synchronised fault. A synchroniser of the wrong depth shifts both the exclusion and the live readback by whole cycles, so the latency is checked on each edge of a fault.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int NBR = 2;
  localparam int CFG_AW = 2;
  localparam int CFG_DW = 4;

  typedef enum logic [CFG_AW-1:0] {
    ADR_ENABLE = 2'd0,
    ADR_MODE   = 2'd1,
    ADR_STICKY = 2'd2,
    ADR_LIVE   = 2'd3
  } cfg_addr_e;

  typedef struct packed {
    logic tx_off;
    logic diag_sel;
    logic diag_en;
  } mode_t;

  // silent bit per branch from the mode
  function automatic logic [NBR-1:0] silent_of(mode_t m);
    logic [NBR-1:0] s;
    s = '0;
    if (m.tx_off) s = '1;
    else if (m.diag_en) begin
      s = '1;
      s[m.diag_sel] = 1'b0;
    end
    return s;
  endfunction

  // wired-AND of included branches; excluded ones read recessive
  function automatic logic merge_rx(logic [NBR-1:0] rxd, logic [NBR-1:0] incl);
    return &(rxd | ~incl);
  endfunction
endpackage

// File: rtl/cmb_fault_sync.sv
module cmb_fault_sync #(
  parameter int NB = 2,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] fault_in,
  output logic [NB-1:0] fault_live
);
  generate
    for (genvar b = 0; b < NB; b++) begin : g_br
      logic [STAGES-1:0] chain;
      logic [STAGES:0]   nxt;
      assign nxt = {chain, fault_in[b]};
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= nxt[STAGES-1:0];
      end
      assign fault_live[b] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cmb_rx_merge.sv
module cmb_rx_merge
  import cmb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NBR-1:0] br_rxd,
  input  logic [NBR-1:0] enable,
  input  logic [NBR-1:0] fault_live,
  output logic           merged_rxd,
  output logic [NBR-1:0] included
);
  assign included   = enable & ~fault_live;
  assign merged_rxd = merge_rx(br_rxd, included);

  // R1: a dominant level on an included branch must reach the controller
  a_r1_dominant_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~br_rxd & included)) |-> !merged_rxd);
  // R3: a branch whose fault is live cannot pull the merged line low alone
  a_r3_faulted_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (&(br_rxd | fault_live)) |-> merged_rxd);
endmodule

// File: rtl/cmb_mode_ctl.sv
module cmb_mode_ctl
  import cmb_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  mode_t          mode,
  output logic [NBR-1:0] silent
);
  assign silent = silent_of(mode);

  // R6: diagnostic mode leaves exactly one talker
  a_r6_one_talker: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.diag_en && !mode.tx_off) |-> ($countones(silent) == NBR - 1));
  // R7: transmit-off silences every branch
  a_r7_all_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    mode.tx_off |-> (&silent));
  // R5: normal mode never silences a branch
  a_r5_normal_talks: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.diag_en && !mode.tx_off) |-> (silent == '0));
endmodule

// File: rtl/cmb_regs.sv
module cmb_regs
  import cmb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  input  logic [NBR-1:0]    fault_live,
  output logic [CFG_DW-1:0] rdata,
  output logic [NBR-1:0]    enable,
  output mode_t             mode,
  output logic [NBR-1:0]    sticky
);
  logic           wr_en, wr_mode, wr_clr;
  logic [NBR-1:0] clr_mask, sticky_d;

  assign wr_en    = we && (addr == ADR_ENABLE);
  assign wr_mode  = we && (addr == ADR_MODE);
  assign wr_clr   = we && (addr == ADR_STICKY);
  assign clr_mask = wr_clr ? wdata[NBR-1:0] : '0;
  assign sticky_d = (sticky & ~clr_mask) | fault_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= '1;
      mode   <= '0;
      sticky <= '0;
    end else begin
      if (wr_en)   enable <= wdata[NBR-1:0];
      if (wr_mode) mode   <= mode_t'(wdata[2:0]);
      sticky <= sticky_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_ENABLE: rdata[NBR-1:0] = enable;
      ADR_MODE:   rdata[2:0]     = mode;
      ADR_STICKY: rdata[NBR-1:0] = sticky;
      default:    rdata[NBR-1:0] = fault_live;
    endcase
  end

  // R8: a live fault is captured on the next edge
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    fault_live[0] |=> sticky[0]);
  // R8: a sticky bit survives unless written with one
  a_r8_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky[1] && !(wr_clr && wdata[1])) |=> sticky[1]);
endmodule

// File: rtl/can_dual_branch_combiner.sv
module can_dual_branch_combiner
  import cmb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_txd,
  output logic              ctl_rxd,
  input  logic [1:0]        br_rxd,
  input  logic [1:0]        br_fault,
  output logic [1:0]        br_txd,
  output logic [1:0]        br_silent,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [3:0]        cfg_wdata,
  output logic [3:0]        cfg_rdata,
  output logic              sys_warn
);
  logic [NBR-1:0] fault_live, enable, sticky, included;
  mode_t          mode;

  cmb_fault_sync #(.NB(NBR), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .fault_in(br_fault), .fault_live(fault_live));

  cmb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .fault_live(fault_live), .rdata(cfg_rdata), .enable(enable), .mode(mode),
    .sticky(sticky));

  cmb_rx_merge u_merge (
    .clk(clk), .rst_n(rst_n), .br_rxd(br_rxd), .enable(enable),
    .fault_live(fault_live), .merged_rxd(ctl_rxd), .included(included));

  cmb_mode_ctl u_mode (
    .clk(clk), .rst_n(rst_n), .mode(mode), .silent(br_silent));

  assign br_txd   = {NBR{ctl_txd}};
  assign sys_warn = |sticky;

  // R10: warning follows the sticky bits
  a_r10_warn: assert property (@(posedge clk) disable iff (!rst_n)
    sys_warn == (sticky != '0));
  // R4: both branches carry the controller's transmit bit
  a_r4_fanout: assert property (@(posedge clk) disable iff (!rst_n)
    (br_txd[0] == ctl_txd) && (br_txd[1] == ctl_txd));
endmodule

// File: tb/can_dual_branch_combiner_test.sv
module can_dual_branch_combiner_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_txd = 1'b1, cfg_we = 1'b0;
  logic [1:0] br_rxd = 2'b11, br_fault = 2'b00, cfg_addr = 2'd0;
  logic [3:0] cfg_wdata = 4'd0;
  logic ctl_rxd, sys_warn;
  logic [1:0] br_txd, br_silent;
  logic [3:0] cfg_rdata;

  int checks = 0, failures = 0;

  // behavioural reference state
  int m_en, m_diag, m_sel, m_off, m_stk;
  int m_pipe[$];   // queue of past fault inputs, newest at back

  can_dual_branch_combiner uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int live_now();
    return m_pipe[0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 3; m_diag = 0; m_sel = 0; m_off = 0; m_stk = 0;
      m_pipe = '{0, 0};
    end else begin
      int lv;
      lv = live_now();
      if (cfg_we && cfg_addr == 2) m_stk = m_stk & ~int'(cfg_wdata[1:0]);
      m_stk = m_stk | lv;
      if (cfg_we && cfg_addr == 0) m_en = cfg_wdata[1:0];
      if (cfg_we && cfg_addr == 1) begin
        m_diag = cfg_wdata[0]; m_sel = cfg_wdata[1]; m_off = cfg_wdata[2];
      end
      void'(m_pipe.pop_front());
      m_pipe.push_back(int'(br_fault));
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int lv, e_rx, e_sil, e_rd;
    lv = live_now();
    e_rx = 1;
    for (int b = 0; b < 2; b++)
      if (m_en[b] && !lv[b] && !br_rxd[b]) e_rx = 0;
    check((lv & m_en) != 0 ? "R3 merge" : (m_en != 3 ? "R2 merge" : "R1 merge"),
          ctl_rxd, e_rx);
    check("R4 fanout", br_txd, ctl_txd ? 3 : 0);
    if (m_off) e_sil = 3;
    else if (m_diag) e_sil = m_sel ? 1 : 2;
    else e_sil = 0;
    check(m_off ? "R7 silent" : (m_diag ? "R6 silent" : "R5 silent"), br_silent, e_sil);
    check("R10 warn", sys_warn, m_stk != 0);
    case (cfg_addr)
      2'd0: e_rd = m_en;
      2'd1: e_rd = m_diag + 2*m_sel + 4*m_off;
      2'd2: e_rd = m_stk;
      default: e_rd = lv;
    endcase
    check(cfg_addr == 0 ? "R2 read" : cfg_addr == 1 ? "R6 read" :
          cfg_addr == 2 ? "R8 read" : "R9 read", cfg_rdata, e_rd);
  endtask

  task automatic step(int n = 1);
    repeat (n) begin
      @(negedge clk);
      compare_all();
    end
  endtask

  task automatic wr(int a, int d);
    cfg_we = 1'b1; cfg_addr = a[1:0]; cfg_wdata = d[3:0];
    step();
    cfg_we = 1'b0;
  endtask

  task automatic traffic(int n, int seed);
    int s = seed;
    for (int i = 0; i < n; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      br_rxd = s[17:16];
      ctl_txd = s[20];
      cfg_addr = s[23:22];
      step();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset values
    cfg_addr = 0; step(); check("R11 enable reset", cfg_rdata, 3);
    cfg_addr = 1; step(); check("R11 mode reset", cfg_rdata, 0);
    cfg_addr = 2; step(); check("R11 sticky reset", cfg_rdata, 0);
    cfg_addr = 3; step(); check("R11 live reset", cfg_rdata, 0);
    traffic(40, 7);                       // R1 both branches in
    wr(0, 1); traffic(20, 11);            // R2 only branch 0
    wr(0, 2); traffic(20, 13);            // R2 only branch 1
    wr(0, 0); traffic(10, 17);            // R2 none
    wr(0, 3);
    wr(3, 3); cfg_addr = 3; step();       // R9 write to live ignored
    check("R9 live write ignored", cfg_rdata, 0);
    // R3/R8 fault on branch 0 with dominant there only
    br_rxd = 2'b10; br_fault = 2'b01; cfg_addr = 3;
    step(); check("R3 not yet excluded", ctl_rxd, 0);
    step(); check("R9 live after two edges", cfg_rdata, 1);
    check("R3 excluded", ctl_rxd, 1);
    cfg_addr = 2; step(); check("R8 sticky set", cfg_rdata, 1);
    wr(2, 1); cfg_addr = 2; step(); check("R8 set wins over clear", cfg_rdata, 1);
    br_fault = 2'b00; step(2);
    check("R3 rejoined", ctl_rxd, 0);
    check("R10 warn still", sys_warn, 1);
    wr(2, 1); cfg_addr = 2; step(); check("R8 cleared", cfg_rdata, 0);
    check("R10 warn off", sys_warn, 0);
    br_fault = 2'b10; traffic(15, 19); br_fault = 2'b00; traffic(10, 23);
    wr(2, 2);
    // R5 R6 R7 modes
    wr(1, 1); traffic(8, 29);
    wr(1, 3); traffic(8, 31);
    check("R6 branch1 talks", br_silent, 1);
    wr(1, 7); traffic(8, 37);
    check("R7 tx off", br_silent, 3);
    wr(1, 4); traffic(4, 41);
    wr(1, 0); traffic(8, 43);
    check("R5 normal", br_silent, 0);
    br_fault = 2'b11; traffic(12, 47); br_fault = 2'b00; traffic(12, 53);
    wr(2, 3); traffic(6, 59);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule